// File: doc/BRIEF.md
# Rational 2/3 Sample-Rate Converter

This block converts a stream of signed fixed-point samples to two thirds of its input rate. Each input word is registered and then up-sampled by two, with a zero placed after every real sample. The up-sampled stream goes through an N-tap anti-aliasing FIR filter, and only every third filter result is kept. The kept result goes through an output register. A single fast clock drives every stage. The clock period is the GCD of the normalized sample periods: input every 2 clocks, filter every clock, output every 3 clocks. Stages take turns through clock enables that come from one modulo-6 phase counter.

Every word carries a valid flag. The output is marked invalid until the filter window holds N consecutive valid up-sampled samples. An invalid input empties that window again. The surrounding logic must present a new input word every second clock, counted from reset release. It reads a result in each cycle where `out_ce` is high.

Top module: `rate_conv_23`

## Requirements
- R1: While `rst_n` is low at a clock edge, the phase counter returns to 0 and every register returns to zero. After that edge, `out_data`, `out_valid` and `out_ce` read 0.
- R2: Call the first rising edge with `rst_n` high cycle 0. The input enable is high in cycles where (cycle mod 6) is 0, 2 or 4. `out_ce` is high in cycles where (cycle mod 6) is 1 or 4, which is exactly 2 pulses in every 6 clocks.
- R3: `in_data` and `in_valid` are captured only at edges where the input enable is high. Values present in odd cycles have no effect on the output.
- R4: Each captured input x_k becomes two filter samples, u[2k] = x_k and then u[2k+1] = 0. Both samples carry the valid flag of x_k.
- R5: The filter result is y[j] = sum over i of h[i]*u[j-i], with samples before reset taken as 0. Coefficient h[i] is the signed value in `COEF[i*CW +: CW]`. The sum keeps full precision, and the word delivered is bits [SHIFT +: OW] of that sum.
- R6: The first `out_ce` pulse after reset delivers data 0 with valid 0. Pulse m+1 (m = 0, 1, ...) delivers y[3m+1].
- R7: The valid flag of y[j] is 1 only when u[j-N+1] through u[j] are all valid and j >= N-1. An invalid input sample clears this condition.
- R8: Over the run, the number of `out_ce` pulses equals two for every three input slots.
- R9: `out_data` and `out_valid` change only in cycles where `out_ce` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one period per up-sampled filter sample |
| rst_n | input | 1 | Synchronous active-low reset |
| in_data | input | DW | Signed input sample, captured on input-enable cycles |
| in_valid | input | 1 | Valid flag that travels with `in_data` |
| out_data | output | OW | Signed truncated filter result |
| out_valid | output | 1 | Valid flag of `out_data` |
| out_ce | output | 1 | High in the cycle in which a new output word appears |

## Verification
The bench builds the block with DW = 12, CW = 8, OW = 12, SHIFT = 4 and five taps. The taps are 2, -3, 7, 5, -1: they are asymmetric and include negative values, so a reversed tap order, a lost sign extension or a misplaced slice produces different output words. With a five-tap window, a one-sample invalid gap clears the valid flag for several outputs, and the refill is visible within a short run. Full-scale positive and negative inputs drive the accumulator close to its upper bits, so bit [SHIFT+OW-1] of the sum is actually exercised.

// File: rtl/rc_pkg.sv
// Package: rc_pkg
// Shared constants for the 2/3 rate converter. The interpolation and
// decimation factors live here so that the enable generator and the top
// agree on the frame length.
package rc_pkg;
    localparam int unsigned RC_UP   = 2;               // interpolation factor
    localparam int unsigned RC_DOWN = 3;               // decimation factor
    localparam int unsigned RC_FRAME = RC_UP * RC_DOWN; // fast clocks per frame
endpackage

// File: rtl/rc_ce_gen.sv
// Module: rc_ce_gen
// Phase counter that produces the per-stage clock enables from one fast
// clock. Assumes UP and DOWN divide FRAME; synchronous active-low reset
// puts the counter at phase 0.
module rc_ce_gen #(
    parameter int unsigned UP    = 2,
    parameter int unsigned DOWN  = 3,
    localparam int unsigned FRAME = UP * DOWN,
    localparam int unsigned PW    = (FRAME > 1) ? $clog2(FRAME) : 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic in_ce,      // input register enable
    output logic stuff_real, // fast cycle that carries the real sample
    output logic out_ce      // output register enable
);
    logic [PW-1:0] phase;

    // Advance the phase modulo FRAME.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == PW'(FRAME - 1))
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // Decode the enables from the phase.
    always_comb begin
        in_ce      = (32'(phase) % UP) == 0;
        stuff_real = (32'(phase) % UP) == 1;
        out_ce     = (32'(phase) % DOWN) == 0;
    end

    // R2: the input enable alternates every clock for a factor of two.
    a_r2_in_ce_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        in_ce |=> !in_ce);
    // R2: two output enables are at least three clocks apart.
    a_r2_out_ce_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        out_ce |=> (!out_ce ##1 !out_ce));
endmodule

// File: rtl/rc_fir.sv
// Module: rc_fir
// N-tap direct-form FIR that runs every fast clock. The window holds the
// entering sample plus N-1 delayed samples. The full-precision sum is sliced
// at SHIFT and registered. The valid output needs N consecutive valid
// samples. Assumes SHIFT+OW <= accumulator width.
module rc_fir #(
    parameter int unsigned N     = 5,
    parameter int unsigned DW    = 12,
    parameter int unsigned CW    = 8,
    parameter int unsigned OW    = 12,
    parameter int unsigned SHIFT = 4,
    parameter logic [N*CW-1:0] COEF = '0,
    localparam int unsigned AW   = DW + CW + $clog2(N + 1),
    localparam int unsigned FW   = $clog2(N + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] x_in,
    input  logic                 x_valid,
    output logic signed [OW-1:0] y_out,
    output logic                 y_valid
);
    logic signed [DW-1:0] taps [N];   // taps[0] newest stored sample
    logic signed [DW-1:0] win  [N];   // window incl. entering sample
    logic signed [AW-1:0] acc;
    logic [FW-1:0]        fill;       // consecutive valid samples stored

    // Window view: entering sample first, then stored history.
    always_comb begin
        win[0] = x_in;
        for (int i = 1; i < N; i++) win[i] = taps[i-1];
    end

    // Shift the delay line every clock.
    generate
        for (genvar g = 0; g < N; g++) begin : g_tap
            always_ff @(posedge clk) begin
                if (!rst_n) taps[g] <= '0;
                else        taps[g] <= win[g];
            end
        end
    endgenerate

    // Full-precision multiply-accumulate over the window.
    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++)
            acc = acc + AW'($signed(win[i]) * $signed(COEF[i*CW +: CW]));
    end

    // Track the run of valid samples, saturating at N.
    always_ff @(posedge clk) begin
        if (!rst_n || !x_valid) fill <= '0;
        else if (fill != FW'(N)) fill <= fill + 1'b1;
    end

    // Register the truncated result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_out   <= '0;
            y_valid <= 1'b0;
        end else begin
            y_out   <= acc[SHIFT +: OW];
            y_valid <= x_valid && (fill >= FW'(N - 1));
        end
    end

    // R7: the run counter never exceeds the window length.
    a_r7_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(N));
    // R7: a valid result requires the previous stored sample run to be valid.
    a_r7_valid_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (x_valid && fill == '0 && N > 1) |=> !y_valid);
endmodule

// File: rtl/rate_conv_23.sv
// Module: rate_conv_23
// 2/3 sample-rate converter: input register, zero-stuffing up-sampler,
// FIR filter, decimating output register, all on one clock with enables.
// Assumes a new input word is presented every second clock from reset
// release; out_ce marks the cycle in which a new output appears.
module rate_conv_23 #(
    parameter int unsigned N_TAPS = 5,
    parameter int unsigned DW     = 12,
    parameter int unsigned CW     = 8,
    parameter int unsigned OW     = 12,
    parameter int unsigned SHIFT  = 4,
    parameter logic [N_TAPS*CW-1:0] COEF = {8'sd1, 8'sd3, 8'sd4, 8'sd3, 8'sd1}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic signed [DW-1:0] in_data,
    input  logic                 in_valid,
    output logic signed [OW-1:0] out_data,
    output logic                 out_valid,
    output logic                 out_ce
);
    import rc_pkg::*;

    logic                 ce_in, ce_out, real_slot;
    logic signed [DW-1:0] in_q;
    logic                 in_q_v;
    logic signed [DW-1:0] up_data;
    logic signed [OW-1:0] fir_data;
    logic                 fir_valid;

    rc_ce_gen #(
        .UP   (RC_UP),
        .DOWN (RC_DOWN)
    ) u_ce (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_ce      (ce_in),
        .stuff_real (real_slot),
        .out_ce     (ce_out)
    );

    // Capture the input word on the input enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_q   <= '0;
            in_q_v <= 1'b0;
        end else if (ce_in) begin
            in_q   <= in_data;
            in_q_v <= in_valid;
        end
    end

    // Zero-stuff: real sample in its slot, zero in the other.
    always_comb up_data = real_slot ? in_q : '0;

    rc_fir #(
        .N     (N_TAPS),
        .DW    (DW),
        .CW    (CW),
        .OW    (OW),
        .SHIFT (SHIFT),
        .COEF  (COEF)
    ) u_fir (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_in    (up_data),
        .x_valid (in_q_v),
        .y_out   (fir_data),
        .y_valid (fir_valid)
    );

    // Keep one filter result per output enable and flag its arrival.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_valid <= 1'b0;
            out_ce    <= 1'b0;
        end else begin
            out_ce <= ce_out;
            if (ce_out) begin
                out_data  <= fir_data;
                out_valid <= fir_valid;
            end
        end
    end

    // R9: the output word holds between output enables.
    a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ce |-> ($stable(out_data) && $stable(out_valid)));
    // R7: the valid flag can only rise together with an output enable.
    a_r7_valid_rise_on_ce: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_ce);
endmodule

// File: tb/tb_rate_conv_23.sv
// Bench for rate_conv_23: a driver task feeds input slots and pushes
// expected outputs from a behavioural zero-stuff / filter / keep-every-
// third model into a queue; a monitor pops and compares on out_ce.
module tb_rate_conv_23;
    localparam int N     = 5;
    localparam int DW    = 12;
    localparam int CW    = 8;
    localparam int OW    = 12;
    localparam int SHIFT = 4;
    localparam int H [N] = '{2, -3, 7, 5, -1};
    localparam logic [N*CW-1:0] COEF =
        {8'(-1), 8'(5), 8'(7), 8'(-3), 8'(2)};   // h[i] at [i*CW +: CW]

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic signed [DW-1:0] in_data = '0;
    logic                 in_valid = 1'b0;
    logic signed [OW-1:0] out_data;
    logic                 out_valid;
    logic                 out_ce;

    rate_conv_23 #(
        .N_TAPS (N), .DW (DW), .CW (CW), .OW (OW), .SHIFT (SHIFT), .COEF (COEF)
    ) dut (
        .clk (clk), .rst_n (rst_n), .in_data (in_data), .in_valid (in_valid),
        .out_data (out_data), .out_valid (out_valid), .out_ce (out_ce)
    );

    always #2 clk = ~clk;   // 250 MHz

    int n_chk = 0;
    int n_bad = 0;
    int n_pulse = 0;
    int n_slots = 0;
    bit done = 1'b0;

    longint u_d[$];
    bit     u_v[$];
    logic [OW:0] exp_q[$];   // {valid, data}

    task automatic check(input bit ok, input string req,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Model: append one up-sampled sample and enqueue a kept result.
    task automatic model_push(input longint d, input bit v);
        longint acc;
        bit     vv;
        int     j;
        u_d.push_back(d);
        u_v.push_back(v);
        j = u_d.size() - 1;
        acc = 0;
        vv = (j >= N - 1);
        for (int i = 0; i < N; i++) begin
            if (j - i >= 0) begin
                acc += longint'(H[i]) * u_d[j-i];
                if (!u_v[j-i]) vv = 1'b0;
            end
        end
        if (j % 3 == 1) exp_q.push_back({vv, OW'(acc >>> SHIFT)});
    endtask

    // Driver: one input slot = two clocks; odd cycle carries junk (R3).
    task automatic send(input int x, input bit v);
        in_data  = DW'(x);
        in_valid = v;
        model_push(longint'(x), v);   // R4: real sample
        model_push(0, v);             // R4: inserted zero
        n_slots++;
        @(negedge clk);
        in_data  = ~DW'(x) ^ 12'h5A5;
        in_valid = ~v;
        @(negedge clk);
    endtask

    // Monitor: compare each delivered word against the queue.
    always @(negedge clk) begin
        if (rst_n && out_ce) begin
            n_pulse++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected output", n_pulse, 0);
            end else begin
                logic [OW:0] e;
                e = exp_q.pop_front();
                check(out_data == $signed(e[OW-1:0]), "R5/R6 data",
                      longint'(out_data), longint'($signed(e[OW-1:0])));
                check(out_valid == e[OW], "R7 valid",
                      longint'(out_valid), longint'(e[OW]));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p0;
        repeat (4) @(negedge clk);
        // R1: reset state.
        check(out_data == 0, "R1 out_data", out_data, 0);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(out_ce == 0, "R1 out_ce", out_ce, 0);
        exp_q.push_back('0);          // R6: first word is zero, invalid
        rst_n = 1'b1;
        // Ramp, valid; R2/R8 pulse count per 3 slots.
        for (int k = 0; k < 12; k++) begin
            if (k % 3 == 0) p0 = n_pulse;
            send(k * 37 - 150, 1'b1);
            if (k % 3 == 2) check(n_pulse - p0 == 2, "R2/R8 pulses per frame",
                                  n_pulse - p0, 2);
        end
        // One invalid slot clears the window (R7), then refill.
        send(500, 1'b0);
        for (int k = 0; k < 11; k++) send((k % 2) ? -700 : 900, 1'b1);
        // Full-scale alternating extremes (R5 slice).
        for (int k = 0; k < 12; k++) send((k % 3 == 0) ? -2048 : 2047, 1'b1);
        // Drain with invalid zeros.
        for (int k = 0; k < 6; k++) send(0, 1'b0);
        // R8: total pulses equal 2 per 3 slots; queue holds the leftover.
        check(n_pulse + exp_q.size() - 1 == (2 * n_slots) / 3,
              "R8 output count", n_pulse + exp_q.size() - 1, (2 * n_slots) / 3);
        check(exp_q.size() <= 2, "R6 pending outputs", exp_q.size(), 2);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule